// File: doc/BRIEF.md
# Serial Port Register Bank

This block is the host-facing side of a simple serial port. A processor reaches it through an APB slave with a small window of word registers: a data port, a read-only status word, a fully writable control word, and two placeholder registers that always read zero. On the line side it takes already-assembled bytes on a valid/ready input and keeps them in a receive FIFO. It hands bytes to be sent to a downstream serializer on a valid/ready output.

Reading the data port takes the oldest received byte and removes it from the FIFO. Writing the data port queues one byte for sending, but only while the transmitter is enabled. Received bytes are kept only while the receiver is enabled. A single interrupt line gives a one-cycle pulse when a byte is taken in or sent out, if the matching interrupt enable is set. Baud timing, serial framing, parity, flow control and the placeholder registers' nominal functions belong to other blocks.

Top module: `serial_port_regbank`

## Requirements
- R1: Decoding uses `paddr`. The data port answers at 0x00 and also at 0x03. Status is at 0x04 and control at 0x08. Offsets 0x0C and 0x10, and every unmapped offset, read as zero.
- R2: After reset, control reads 0, status reads 0x0000_0006 (bit 1 and bit 2 set), the receive FIFO is empty and `rx_ready` is high.
- R3: Control stores all 32 bits written to it and reads them back unchanged. Writes to status, 0x0C and 0x10 change no register.
- R4: A byte offered on `rx_data`/`rx_valid` enters the FIFO only when control bit 0 is set. Once a byte is held, status bit 0 (data ready) is set.
- R5: A data-port read returns the oldest held byte in bits 7:0 and removes it. Status bit 0 clears when the last byte leaves. A read of an empty FIFO returns 0 and changes nothing.
- R6: The FIFO is popped only in the access phase of an APB read (`psel` and `penable` both high). A setup phase on its own removes nothing.
- R7: With `RX_DEPTH` bytes held, `rx_ready` is low and status bit 10 is set. Status bit 8 is set while at least `RX_DEPTH/2` bytes are held. A byte offered while full with the receiver enabled is dropped and sets status bit 4 (overrun), which stays set until reset.
- R8: A data-port write with control bit 1 set presents `pwdata[7:0]` on `tx_data` with `tx_valid` high until `tx_ready`. While a byte is held, status bits 1 and 2 are low and bit 9 is high. A write with control bit 1 clear, or a write while a byte is already held, sends nothing.
- R9: `irq` is high for exactly the one cycle after a byte is received with control bit 2 set, or after a byte is taken for sending with control bit 3 set. Both events in the same cycle give a single one-cycle pulse. At all other times `irq` is low.
- R10: `pready` is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant high |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Serializer takes the byte |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench fills the FIFO to its last slot and offers one more byte. A design that wrapped its pointers would later hand back a corrupted or extra byte, and one that ignored the full case would never raise overrun. It holds a setup phase on the data port with no access phase. A design that popped on `psel` alone would lose a byte there. It reads the empty FIFO and reads through the 0x03 alias, and writes the data port while a byte is still waiting. A design that replaced the held byte would send the wrong value or pulse the interrupt a second time. It also lines a receive and a send up on the same edge. A design that counted each event separately would stretch `irq` to two cycles.

// File: rtl/sport_pkg.sv
package sport_pkg;
   localparam int REG_W  = 32;
   localparam int BYTE_W = 8;

   localparam logic [7:0] OFS_DATA   = 8'h00;
   localparam logic [7:0] OFS_DATA_B = 8'h03;
   localparam logic [7:0] OFS_STAT   = 8'h04;
   localparam logic [7:0] OFS_CTRL   = 8'h08;
   localparam logic [7:0] OFS_SCALE  = 8'h0C;
   localparam logic [7:0] OFS_DBG    = 8'h10;

   // status bit positions
   localparam int ST_DREADY  = 0;
   localparam int ST_TSH_EMP = 1;
   localparam int ST_TFF_EMP = 2;
   localparam int ST_OVERRUN = 4;
   localparam int ST_RX_HALF = 8;
   localparam int ST_TX_FULL = 9;
   localparam int ST_RX_FULL = 10;

   // control bit positions
   localparam int CT_RXEN = 0;
   localparam int CT_TXEN = 1;
   localparam int CT_RXIE = 2;
   localparam int CT_TXIE = 3;

   typedef enum logic [1:0] {SEL_ZERO, SEL_DATA, SEL_STAT, SEL_CTRL} regsel_e;

   function automatic regsel_e decode_ofs(input logic [7:0] ofs);
      case (ofs)
         OFS_DATA, OFS_DATA_B: decode_ofs = SEL_DATA;
         OFS_STAT:             decode_ofs = SEL_STAT;
         OFS_CTRL:             decode_ofs = SEL_CTRL;
         default:              decode_ofs = SEL_ZERO;
      endcase
   endfunction
endpackage

// File: rtl/sport_rx_fifo.sv
module sport_rx_fifo #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full,
   output logic             half
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sport_rx_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp;

   assign empty = (count == '0);
   assign full  = (count == FULL_CNT);
   assign half  = (count >= HALF_CNT);
   assign head  = empty ? '0 : mem[rp];

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: a full FIFO is never written
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);
   // R5: an empty FIFO is never popped
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);
   // R5: removing the last byte leaves the FIFO empty
   a_r5_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && count == CNT_W'(1)) |=> empty);
endmodule

// File: rtl/sport_tx_hold.sv
module sport_tx_hold #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic             took,
   output logic [WIDTH-1:0] tx_data,
   output logic             tx_valid,
   input  logic             tx_ready
);
   assign took = load && !tx_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (took) begin
         tx_valid <= 1'b1;
         tx_data  <= din;
      end else if (tx_valid && tx_ready) begin
         tx_valid <= 1'b0;
      end
   end

   // R8: an offered byte is held unchanged until the consumer takes it
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/sport_irq_pulse.sv
module sport_irq_pulse #(
   parameter int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] events,
   output logic             irq
);
   generate
      if (N_SRC < 1) begin : g_bad_src
         $error("sport_irq_pulse: N_SRC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |events;
   end
endmodule

// File: rtl/serial_port_regbank.sv
module serial_port_regbank
   import sport_pkg::*;
#(
   parameter int RX_DEPTH = 1024,
   localparam int CNT_W = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [7:0]        paddr,
   input  logic [REG_W-1:0]  pwdata,
   output logic [REG_W-1:0]  prdata,
   output logic              pready,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              irq
);
   regsel_e           sel;
   logic              acc_wr, acc_rd;
   logic [REG_W-1:0]  ctrl_q;
   logic              overrun_q;
   logic              rx_take, rx_lost, rx_pop;
   logic [BYTE_W-1:0] rx_head;
   logic [CNT_W-1:0]  rx_cnt;
   logic              rx_empty, rx_full, rx_half;
   logic              tx_load, tx_took;
   logic [REG_W-1:0]  status;

   assign pready = 1'b1;
   assign sel    = decode_ofs(paddr);
   assign acc_wr = psel && penable && pwrite;
   assign acc_rd = psel && penable && !pwrite;

   always_ff @(posedge clk) begin
      if (!rst_n)                        ctrl_q <= '0;
      else if (acc_wr && sel == SEL_CTRL) ctrl_q <= pwdata;
   end

   // receive path
   assign rx_ready = !rx_full;
   assign rx_take  = rx_valid && !rx_full && ctrl_q[CT_RXEN];
   assign rx_lost  = rx_valid && rx_full && ctrl_q[CT_RXEN];
   assign rx_pop   = acc_rd && sel == SEL_DATA && !rx_empty;

   always_ff @(posedge clk) begin
      if (!rst_n)       overrun_q <= 1'b0;
      else if (rx_lost) overrun_q <= 1'b1;
   end

   sport_rx_fifo #(.DEPTH(RX_DEPTH), .WIDTH(BYTE_W)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_take), .din(rx_data), .pop(rx_pop), .head(rx_head),
      .count(rx_cnt), .empty(rx_empty), .full(rx_full), .half(rx_half)
   );

   // transmit path
   assign tx_load = acc_wr && sel == SEL_DATA && ctrl_q[CT_TXEN];

   sport_tx_hold #(.WIDTH(BYTE_W)) u_txh (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .din(pwdata[BYTE_W-1:0]),
      .took(tx_took), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
   );

   sport_irq_pulse #(.N_SRC(2)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .events({tx_took && ctrl_q[CT_TXIE], rx_take && ctrl_q[CT_RXIE]}),
      .irq(irq)
   );

   always_comb begin
      status             = '0;
      status[ST_DREADY]  = !rx_empty;
      status[ST_TSH_EMP] = !tx_valid;
      status[ST_TFF_EMP] = !tx_valid;
      status[ST_OVERRUN] = overrun_q;
      status[ST_RX_HALF] = rx_half;
      status[ST_TX_FULL] = tx_valid;
      status[ST_RX_FULL] = rx_full;
   end

   always_comb begin
      case (sel)
         SEL_DATA: prdata = {{(REG_W-BYTE_W){1'b0}}, rx_head};
         SEL_STAT: prdata = status;
         SEL_CTRL: prdata = ctrl_q;
         default:  prdata = '0;
      endcase
   end

   // R10: ready is never withdrawn
   a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n) pready);
   // R3: writing status leaves control untouched
   a_r3_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && sel == SEL_STAT) |=> $stable(ctrl_q));
   // R4: with the receiver off, offered bytes do not change the fill level
   a_r4_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !ctrl_q[CT_RXEN] && !rx_pop) |=> $stable(rx_cnt));
   // R6: nothing leaves the FIFO outside an access phase
   a_r6_setup_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (!penable && !(rx_valid && rx_ready)) |=> (rx_cnt >= $past(rx_cnt)));
   // R7: full FIFO withdraws ready
   a_r7_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == CNT_W'(RX_DEPTH)) |-> !rx_ready);
   // R9: every pulse follows a qualifying bus or line event
   a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past((rx_valid && rx_ready && ctrl_q[CT_RXIE])
                    || (acc_wr && sel == SEL_DATA && ctrl_q[CT_TXIE])));
endmodule

// File: tb/sim_serial_port_regbank.sv
module sim_serial_port_regbank;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rx_exp[$];
   logic [7:0] tx_exp[$];
   logic       last_irq;
   logic [31:0] rd_val;
   bit         done = 0;

   always #2 clk = ~clk;

   serial_port_regbank #(.RX_DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge clk); penable = 1;
      @(negedge clk); psel = 0; penable = 0; pwrite = 0;
      #1 last_irq = irq;
   endtask

   task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge clk); penable = 1;
      #1 d = prdata;
      @(negedge clk); psel = 0; penable = 0;
   endtask

   task automatic rx_send(input logic [7:0] b, input bit expect_keep);
      @(negedge clk); rx_valid = 1; rx_data = b;
      @(negedge clk); rx_valid = 0;
      if (expect_keep) rx_exp.push_back(b);
      #1 last_irq = irq;
   endtask

   // scoreboard read: pops the expected receive queue and compares
   task automatic rx_pull(input string tag, input logic [7:0] a);
      logic [31:0] v;
      logic [7:0]  e;
      apb_read(a, v);
      e = (rx_exp.size() > 0) ? rx_exp.pop_front() : 8'h00;
      chk(tag, v, {24'h0, e});
   endtask

   // transmit monitor
   always @(negedge clk) begin
      #1;
      if (rst_n && tx_valid && tx_ready) begin
         if (tx_exp.size() == 0) chk("R8 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
         else chk("R8 tx byte", {24'h0, tx_data}, {24'h0, tx_exp.pop_front()});
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk("R10 pready", {31'h0, pready}, 32'h1);
      chk("R2 rx_ready after reset", {31'h0, rx_ready}, 32'h1);
      apb_read(8'h04, rd_val); chk("R2 status reset", rd_val, 32'h6);
      apb_read(8'h08, rd_val); chk("R2 control reset", rd_val, 32'h0);
      apb_read(8'h00, rd_val); chk("R5 empty read", rd_val, 32'h0);

      apb_write(8'h08, 32'h8000_1AF0);
      apb_read(8'h08, rd_val); chk("R3 control readback", rd_val, 32'h8000_1AF0);
      apb_write(8'h04, 32'hFFFF_FFFF);
      apb_read(8'h04, rd_val); chk("R3 status ignores write", rd_val, 32'h6);
      apb_write(8'h0C, 32'h55);
      apb_read(8'h0C, rd_val); chk("R1 scaler reads zero", rd_val, 32'h0);
      apb_write(8'h10, 32'h77);
      apb_read(8'h10, rd_val); chk("R1 debug reads zero", rd_val, 32'h0);
      apb_read(8'h08, rd_val); chk("R3 control kept", rd_val, 32'h8000_1AF0);
      apb_read(8'h20, rd_val); chk("R1 unmapped zero", rd_val, 32'h0);

      // receiver disabled
      apb_write(8'h08, 32'h0);
      rx_send(8'h11, 0);
      chk("R9 no irq when disabled", {31'h0, last_irq}, 32'h0);
      apb_read(8'h04, rd_val); chk("R4 disabled rx ignored", rd_val, 32'h6);

      // receiver with interrupt
      apb_write(8'h08, 32'h5);
      rx_send(8'hA1, 1); chk("R9 rx irq", {31'h0, last_irq}, 32'h1);
      #4 chk("R9 irq one cycle", {31'h0, irq}, 32'h0);
      rx_send(8'hB2, 1);
      rx_send(8'hC3, 1);
      apb_read(8'h04, rd_val); chk("R4 data ready", rd_val, 32'h7);
      rx_pull("R1 alias 0x03 read", 8'h03);
      rx_pull("R5 second byte", 8'h00);
      @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = 8'h00;
      @(negedge clk); @(negedge clk); psel = 0;
      apb_read(8'h04, rd_val); chk("R6 setup phase no pop", rd_val, 32'h7);
      rx_pull("R6 byte kept", 8'h00);
      apb_read(8'h04, rd_val); chk("R5 data ready clears", rd_val, 32'h6);
      apb_read(8'h00, rd_val); chk("R5 empty after drain", rd_val, 32'h0);

      // fill to capacity, no interrupts
      apb_write(8'h08, 32'h1);
      for (int i = 0; i < DEPTH / 2 - 1; i++) rx_send(8'h40 + 8'(i), 1);
      chk("R9 no irq without enable", {31'h0, last_irq}, 32'h0);
      apb_read(8'h04, rd_val); chk("R7 below half", rd_val, 32'h7);
      rx_send(8'h40 + 8'(DEPTH / 2 - 1), 1);
      apb_read(8'h04, rd_val); chk("R7 half set", rd_val, 32'h107);
      for (int i = DEPTH / 2; i < DEPTH; i++) rx_send(8'h40 + 8'(i), 1);
      apb_read(8'h04, rd_val); chk("R7 full status", rd_val, 32'h507);
      chk("R7 rx_ready low", {31'h0, rx_ready}, 32'h0);
      rx_send(8'hEE, 0);
      apb_read(8'h04, rd_val); chk("R7 overrun set", rd_val, 32'h517);
      for (int i = 0; i < DEPTH; i++) rx_pull("R7 drain order", 8'h00);
      apb_read(8'h00, rd_val); chk("R7 dropped byte absent", rd_val, 32'h0);
      apb_read(8'h04, rd_val); chk("R7 overrun sticky", rd_val, 32'h16);

      // transmit
      apb_write(8'h00, 32'h5A);
      chk("R8 tx disabled", {31'h0, tx_valid}, 32'h0);
      apb_write(8'h08, 32'hA);
      tx_exp.push_back(8'hA7);
      apb_write(8'h00, 32'h1A7);
      chk("R9 tx irq", {31'h0, last_irq}, 32'h1);
      chk("R8 tx valid", {31'h0, tx_valid}, 32'h1);
      chk("R8 tx data low byte", {24'h0, tx_data}, 32'hA7);
      apb_read(8'h04, rd_val); chk("R8 status busy", rd_val, 32'h210);
      apb_write(8'h00, 32'h33);
      chk("R8 busy write no irq", {31'h0, last_irq}, 32'h0);
      chk("R8 held byte unchanged", {24'h0, tx_data}, 32'hA7);
      @(negedge clk); tx_ready = 1;
      @(negedge clk); #1;
      chk("R8 tx drained", {31'h0, tx_valid}, 32'h0);
      apb_read(8'h04, rd_val); chk("R8 status idle", rd_val, 32'h16);

      // simultaneous receive and send
      apb_write(8'h08, 32'hF);
      @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 8'h00; pwdata = 32'h3C;
      tx_exp.push_back(8'h3C);
      @(negedge clk); penable = 1; rx_valid = 1; rx_data = 8'h99;
      rx_exp.push_back(8'h99);
      @(negedge clk); psel = 0; penable = 0; pwrite = 0; rx_valid = 0;
      #1 chk("R9 merged pulse", {31'h0, irq}, 32'h1);
      @(negedge clk); #1 chk("R9 merged one cycle", {31'h0, irq}, 32'h0);
      rx_pull("R4 simultaneous byte", 8'h00);
      repeat (2) @(negedge clk);
      chk("R8 all tx seen", tx_exp.size(), 32'h0);
      chk("R10 pready end", {31'h0, pready}, 32'h1);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule